// File: doc/BRIEF.md
# Router Power-State Handshake Controller

This block is the per-router controller that decides when a mesh router may cut its own power and when it must come back. Once the attached core has gone to sleep and no traffic has moved to or from it for a set time, the router enters a draining phase. It tells its four neighbours to stop opening new packets towards it, and it waits until its input buffers are empty and every neighbour has confirmed that any packet already in flight has finished. Only then does it gate its datapath and turn on the straight-through bypass. A later request, either from the core or from a neighbour holding a packet for that core, sends it through a wake-up phase and back to normal operation.

Two routers that are physical neighbours never gate at the same time. A router does not begin to drain while a neighbour is draining or asleep. When two adjacent routers start draining in the same window, the router with the lower identifier wins. A timeout returns a stuck drain to normal operation. The controller also keeps a 2-bit record of each neighbour's power state. From that record it derives its own drain-done acknowledges, a hold on new transmissions, and the credit zero and credit refill strobes.

Top module: `pg_handshake_ctrl`

## Requirements
- R1: During and right after reset the controller is Active. Every neighbour record reads Active (00), bypass and gate request are low, and only the active broadcast line is high.
- R2: State codes are Active=0, Draining=1, Sleep=2, Wakeup=3. Exactly one of the four broadcast outputs is high and it names the current state.
- R3: From Active, Draining is entered after IDLE_CYC+1 consecutive cycles in which the core is asleep and no core traffic is seen. Any traffic cycle or core-awake cycle restarts the count.
- R4: Draining is not entered while any present neighbour's record is Draining or Sleep.
- R5: In Draining, a present neighbour asserting its drain line with an identifier below the local one sends the controller back to Active on the next cycle. A neighbour with a higher identifier has no effect. This check takes priority over every other Draining exit.
- R6: The controller spends at most DRAIN_CYC cycles in Draining before it returns to Active.
- R7: If no timeout occurs, Draining goes back to Active when the core wakes. Otherwise it moves to Sleep once the input buffers are empty and every present neighbour asserts drain-done.
- R8: In Sleep the gate request is high. Sleep moves to Wakeup when the core is awake or when a present neighbour requests delivery to the local core. Requests from absent neighbours are ignored.
- R9: Bypass is high in Sleep and Wakeup only. Wakeup returns to Active when the output latches are empty and every present neighbour asserts drain-done.
- R10: A neighbour's record takes the observed state at the next clock edge. If several lines are high at once, priority runs wakeup > sleep > drain > active. Lines from an absent neighbour leave its record unchanged.
- R11: For a present neighbour whose record is Draining or Wakeup, the hold output is high. The drain-done output is high in that case unless a transmission towards that neighbour is still busy.
- R12: A credit-zero strobe is high in the cycle a present neighbour's sleep line is seen while its record is not yet Sleep. A credit-refill strobe is high in the cycle its active line is seen while its record is Wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| router_id | input | ID_W | Local router identifier |
| core_asleep | input | 1 | Attached core is powered down |
| core_traffic | input | 1 | A packet moved to or from the core this cycle |
| inbuf_empty | input | 1 | All input buffers are empty |
| outlatch_empty | input | 1 | All bypass output latches are empty |
| nb_present | input | NB | A physical neighbour exists in that direction |
| nb_drain | input | NB | Neighbour broadcasts Draining |
| nb_sleep | input | NB | Neighbour broadcasts Sleep |
| nb_wake | input | NB | Neighbour broadcasts Wakeup |
| nb_active | input | NB | Neighbour broadcasts Active |
| nb_done | input | NB | Neighbour acknowledges drain-done to this router |
| nb_deliver | input | NB | Neighbour holds a packet for the local core |
| nb_id | input | NB*ID_W | Neighbour identifiers, direction i at bits i*ID_W |
| tx_busy | input | NB | A packet towards that neighbour is still in progress |
| bc_active | output | 1 | Broadcast: Active |
| bc_drain | output | 1 | Broadcast: Draining |
| bc_sleep | output | 1 | Broadcast: Sleep |
| bc_wake | output | 1 | Broadcast: Wakeup |
| done_out | output | NB | Drain-done acknowledge to each neighbour |
| hold_tx | output | NB | Do not start new packets towards that neighbour |
| bypass_en | output | 1 | Straight-through links enabled |
| pg_req | output | 1 | Request to gate the router datapath |
| cred_zero | output | NB | Zero credit counters for that output |
| cred_full | output | NB | Set credit counters of that output to full |
| psr_flat | output | 2*NB | Neighbour state records, 2 bits each |

## Verification
Directed sequences step through the complete Active, Draining, Sleep, Wakeup and Active cycle. They count cycles to separate an idle count that restarts from one that saturates, and a timeout that fires at DRAIN_CYC from one off by a cycle. Two simultaneous drain contests, one against a higher and one against a lower neighbour identifier, show whether the identifier comparison points the right way. Stacked neighbour lines and absent-neighbour stimuli check the record priority and the masking of missing directions. A long constrained-random phase draws sparse neighbour broadcasts, acknowledges and delivery requests, with the core mostly asleep. It is compared every cycle against a reference model, which exercises the exit priorities in Draining and the credit strobes in orders the directed cases do not reach.

// File: rtl/pg_handshake_ctrl.sv
module pg_handshake_ctrl #(
  parameter int ID_W      = 6,
  parameter int IDLE_CYC  = 8,
  parameter int DRAIN_CYC = 20,
  parameter int NB        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    router_id,
  input  logic               core_asleep,
  input  logic               core_traffic,
  input  logic               inbuf_empty,
  input  logic               outlatch_empty,
  input  logic [NB-1:0]      nb_present,
  input  logic [NB-1:0]      nb_drain,
  input  logic [NB-1:0]      nb_sleep,
  input  logic [NB-1:0]      nb_wake,
  input  logic [NB-1:0]      nb_active,
  input  logic [NB-1:0]      nb_done,
  input  logic [NB-1:0]      nb_deliver,
  input  logic [NB*ID_W-1:0] nb_id,
  input  logic [NB-1:0]      tx_busy,
  output logic               bc_active,
  output logic               bc_drain,
  output logic               bc_sleep,
  output logic               bc_wake,
  output logic [NB-1:0]      done_out,
  output logic [NB-1:0]      hold_tx,
  output logic               bypass_en,
  output logic               pg_req,
  output logic [NB-1:0]      cred_zero,
  output logic [NB-1:0]      cred_full,
  output logic [2*NB-1:0]    psr_flat
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int DW = $clog2(DRAIN_CYC + 1);

  typedef enum logic [1:0] {P_ACT = 2'd0, P_DRN = 2'd1, P_SLP = 2'd2, P_WAK = 2'd3} pst_t;

  pst_t            st, st_n;
  logic [IW-1:0]   idle_q;
  logic [DW-1:0]   drn_q;
  logic [2*NB-1:0] psr_q, psr_n;
  logic [NB-1:0]   blk, lose, dn_ok;
  logic            quiet;

  assign quiet = core_asleep && !core_traffic;

  always_comb begin
    psr_n = psr_q;
    for (int i = 0; i < NB; i++) begin
      logic [1:0] cur;
      cur = psr_q[2*i +: 2];
      if (nb_present[i]) begin
        if (nb_wake[i])        psr_n[2*i +: 2] = P_WAK;
        else if (nb_sleep[i])  psr_n[2*i +: 2] = P_SLP;
        else if (nb_drain[i])  psr_n[2*i +: 2] = P_DRN;
        else if (nb_active[i]) psr_n[2*i +: 2] = P_ACT;
      end
      blk[i]       = nb_present[i] && (cur == P_DRN || cur == P_SLP);
      hold_tx[i]   = nb_present[i] && (cur == P_DRN || cur == P_WAK);
      done_out[i]  = hold_tx[i] && !tx_busy[i];
      lose[i]      = nb_present[i] && nb_drain[i] && (nb_id[i*ID_W +: ID_W] < router_id);
      dn_ok[i]     = !nb_present[i] || nb_done[i];
      cred_zero[i] = nb_present[i] && psr_n[2*i +: 2] == P_SLP && cur != P_SLP;
      cred_full[i] = nb_present[i] && psr_n[2*i +: 2] == P_ACT && cur == P_WAK;
    end
  end

  always_comb begin
    st_n = st;
    case (st)
      P_ACT: if (quiet && idle_q == IW'(IDLE_CYC) && blk == '0) st_n = P_DRN;
      P_DRN: begin
        if (|lose)                          st_n = P_ACT;
        else if (drn_q == DW'(DRAIN_CYC-1)) st_n = P_ACT;
        else if (!core_asleep)              st_n = P_ACT;
        else if (inbuf_empty && &dn_ok)     st_n = P_SLP;
      end
      P_SLP: if (!core_asleep || |(nb_deliver & nb_present)) st_n = P_WAK;
      P_WAK: if (outlatch_empty && &dn_ok) st_n = P_ACT;
      default: st_n = P_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= P_ACT;
      idle_q <= '0;
      drn_q  <= '0;
      psr_q  <= '0;
    end else begin
      st     <= st_n;
      psr_q  <= psr_n;
      if (st == P_ACT && quiet)
        idle_q <= (idle_q == IW'(IDLE_CYC)) ? idle_q : idle_q + IW'(1);
      else
        idle_q <= '0;
      drn_q <= (st == P_DRN && st_n == P_DRN) ? drn_q + DW'(1) : '0;
    end
  end

  assign bc_active = st == P_ACT;
  assign bc_drain  = st == P_DRN;
  assign bc_sleep  = st == P_SLP;
  assign bc_wake   = st == P_WAK;
  assign bypass_en = st == P_SLP || st == P_WAK;
  assign pg_req    = st == P_SLP;
  assign psr_flat  = psr_q;

  // R3
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bc_drain) |-> $past(core_asleep) && !$past(core_traffic));

  // R4
  no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bc_drain) |-> $past(blk) == '0);

  // R7
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bc_sleep) |-> $past(bc_drain) && $past(inbuf_empty));

  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bc_wake) |-> $past(bc_sleep));

  // R9
  bypass_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_en) |-> bc_active && $past(outlatch_empty));

  // R10
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nb_present[0] |=> psr_flat[1:0] == $past(psr_flat[1:0]));

  // R2
  onehot_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bc_active, bc_drain, bc_sleep, bc_wake}) && (bc_active || bc_drain || bc_sleep || bc_wake));
endmodule

// File: tb/pg_handshake_ctrl_test.sv
module pg_handshake_ctrl_test;
  localparam int ID_W = 4, IDLE = 4, DRN = 6, NB = 4;

  logic clk = 0, rst_n = 0;
  logic [ID_W-1:0] router_id;
  logic core_asleep, core_traffic, inbuf_empty, outlatch_empty;
  logic [NB-1:0] nb_present, nb_drain, nb_sleep, nb_wake, nb_active, nb_done, nb_deliver, tx_busy;
  logic [NB*ID_W-1:0] nb_id;
  logic bc_active, bc_drain, bc_sleep, bc_wake, bypass_en, pg_req;
  logic [NB-1:0] done_out, hold_tx, cred_zero, cred_full;
  logic [2*NB-1:0] psr_flat;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pg_handshake_ctrl #(.ID_W(ID_W), .IDLE_CYC(IDLE), .DRAIN_CYC(DRN), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .router_id(router_id), .core_asleep(core_asleep),
    .core_traffic(core_traffic), .inbuf_empty(inbuf_empty), .outlatch_empty(outlatch_empty),
    .nb_present(nb_present), .nb_drain(nb_drain), .nb_sleep(nb_sleep), .nb_wake(nb_wake),
    .nb_active(nb_active), .nb_done(nb_done), .nb_deliver(nb_deliver), .nb_id(nb_id),
    .tx_busy(tx_busy), .bc_active(bc_active), .bc_drain(bc_drain), .bc_sleep(bc_sleep),
    .bc_wake(bc_wake), .done_out(done_out), .hold_tx(hold_tx), .bypass_en(bypass_en),
    .pg_req(pg_req), .cred_zero(cred_zero), .cred_full(cred_full), .psr_flat(psr_flat));

  int m_st, m_idle, m_dcnt;
  logic [1:0] m_psr [NB];

  function automatic logic [1:0] rec_next(int i);
    if (!nb_present[i]) return m_psr[i];
    if (nb_wake[i])   return 2'd3;
    if (nb_sleep[i])  return 2'd2;
    if (nb_drain[i])  return 2'd1;
    if (nb_active[i]) return 2'd0;
    return m_psr[i];
  endfunction

  function automatic int state_next();
    bit quiet, blk, lose, dok, dlv;
    quiet = core_asleep && !core_traffic;
    blk = 0; lose = 0; dok = 1; dlv = 0;
    for (int i = 0; i < NB; i++) if (nb_present[i]) begin
      if (m_psr[i] == 2'd1 || m_psr[i] == 2'd2) blk = 1;
      if (nb_drain[i] && nb_id[i*ID_W +: ID_W] < router_id) lose = 1;
      if (!nb_done[i]) dok = 0;
      if (nb_deliver[i]) dlv = 1;
    end
    case (m_st)
      0: return (quiet && m_idle == IDLE && !blk) ? 1 : 0;
      1: begin
        if (lose) return 0;
        if (m_dcnt == DRN-1) return 0;
        if (!core_asleep) return 0;
        if (inbuf_empty && dok) return 2;
        return 1;
      end
      2: return (!core_asleep || dlv) ? 3 : 2;
      default: return (outlatch_empty && dok) ? 0 : 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idle = 0; m_dcnt = 0;
      for (int i = 0; i < NB; i++) m_psr[i] = 2'd0;
    end else begin
      int ns;
      logic [1:0] np [NB];
      ns = state_next();
      for (int i = 0; i < NB; i++) np[i] = rec_next(i);
      m_idle = (m_st == 0 && core_asleep && !core_traffic) ? ((m_idle == IDLE) ? IDLE : m_idle + 1) : 0;
      m_dcnt = (m_st == 1 && ns == 1) ? m_dcnt + 1 : 0;
      m_st = ns;
      for (int i = 0; i < NB; i++) m_psr[i] = np[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [3:0] e_bc;
    logic [NB-1:0] e_done, e_hold, e_cz, e_cf;
    logic [2*NB-1:0] e_psr;
    e_bc = 4'b0001 << m_st;
    for (int i = 0; i < NB; i++) begin
      logic [1:0] nx;
      nx = rec_next(i);
      e_hold[i] = nb_present[i] && (m_psr[i] == 2'd1 || m_psr[i] == 2'd3);
      e_done[i] = e_hold[i] && !tx_busy[i];
      e_cz[i] = nb_present[i] && nx == 2'd2 && m_psr[i] != 2'd2;
      e_cf[i] = nb_present[i] && nx == 2'd0 && m_psr[i] == 2'd3;
      e_psr[2*i +: 2] = m_psr[i];
    end
    chk({bc_wake, bc_sleep, bc_drain, bc_active} == e_bc, "R2 state", {bc_wake, bc_sleep, bc_drain, bc_active}, e_bc);
    chk(bypass_en == (m_st >= 2), "R9 bypass", bypass_en, m_st >= 2);
    chk(pg_req == (m_st == 2), "R8 pg_req", pg_req, m_st == 2);
    chk(psr_flat == e_psr, "R10 records", psr_flat, e_psr);
    chk(done_out == e_done && hold_tx == e_hold, "R11 done/hold", {hold_tx, done_out}, {e_hold, e_done});
    chk(cred_zero == e_cz && cred_full == e_cf, "R12 credit", {cred_full, cred_zero}, {e_cf, e_cz});
  endtask

  task automatic settle(); #5; check_all(); endtask
  task automatic edge_(); @(negedge clk); endtask
  task automatic tick(); settle(); edge_(); endtask

  task automatic quiet_inputs();
    core_asleep = 0; core_traffic = 0; inbuf_empty = 0; outlatch_empty = 0;
    nb_present = 4'hF; nb_drain = 0; nb_sleep = 0; nb_wake = 0; nb_active = 0;
    nb_done = 0; nb_deliver = 0; tx_busy = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    router_id = 4'd7;
    nb_id = {4'd14, 4'd3, 4'd9, 4'd12};
    quiet_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    chk(bc_active && !bc_drain && !bc_sleep && !bc_wake, "R1 reset state", {bc_wake, bc_sleep, bc_drain, bc_active}, 4'b0001);
    chk(psr_flat == '0 && !bypass_en && !pg_req, "R1 reset outputs", {psr_flat, bypass_en, pg_req}, 0);
    edge_();

    // R3: quiet count restarts on traffic
    core_asleep = 1;
    repeat (3) tick();
    core_traffic = 1; tick(); core_traffic = 0;
    n = 0;
    while (!bc_drain && n < 50) begin tick(); n++; end
    chk(n == IDLE + 1, "R3 idle wait", n, IDLE + 1);

    // R6: timeout with buffers never empty
    n = 0;
    while (bc_drain && n < 50) begin tick(); n++; end
    chk(n == DRN, "R6 drain timeout", n, DRN);
    chk(bc_active, "R6 back to active", bc_active, 1);
    core_asleep = 0; tick(); core_asleep = 1;

    // R5: contest against higher then lower id
    n = 0;
    while (!bc_drain && n < 50) begin tick(); n++; end
    nb_drain[0] = 1; tick();
    chk(bc_drain, "R5 higher id ignored", bc_drain, 1);
    nb_drain[2] = 1; tick();
    chk(bc_active, "R5 lower id wins", bc_active, 1);
    nb_drain = 0; nb_active = 4'b0101; tick(); nb_active = 0;

    // R4: sleeping neighbour blocks drain, with R12 credit strobes
    nb_sleep[1] = 1;
    settle();
    chk(cred_zero == 4'b0010, "R12 credit zero", cred_zero, 4'b0010);
    edge_();
    repeat (3 * IDLE) tick();
    chk(bc_active, "R4 blocked by sleeping neighbour", bc_active, 1);
    nb_sleep = 0; nb_wake[1] = 1; tick(); nb_wake = 0;
    nb_active[1] = 1;
    settle();
    chk(cred_full == 4'b0010, "R12 credit refill", cred_full, 4'b0010);
    edge_();
    nb_active = 0;

    // R7: sleep needs every acknowledge
    n = 0;
    while (!bc_drain && n < 50) begin tick(); n++; end
    inbuf_empty = 1; nb_done = 4'b0111; tick();
    chk(bc_drain, "R7 waits for all done", bc_drain, 1);
    nb_done = 4'hF; tick();
    chk(bc_sleep && pg_req && bypass_en, "R7 enters sleep", {bc_sleep, pg_req, bypass_en}, 3'b111);
    nb_done = 0;

    // R8: absent neighbour delivery ignored, present one wakes
    nb_present[3] = 0; nb_deliver[3] = 1; tick();
    chk(bc_sleep, "R8 absent delivery ignored", bc_sleep, 1);
    nb_present[3] = 1; tick(); nb_deliver = 0;
    chk(bc_wake && bypass_en && !pg_req, "R9 wakeup outputs", {bc_wake, bypass_en, pg_req}, 3'b110);
    outlatch_empty = 1; tick();
    chk(bc_wake, "R9 waits for done", bc_wake, 1);
    nb_done = 4'hF; tick();
    chk(bc_active && !bypass_en, "R9 back to active", {bc_active, bypass_en}, 2'b10);
    nb_done = 0; core_asleep = 0;

    // R10: priority and absent masking
    nb_wake[0] = 1; nb_sleep[0] = 1; nb_drain[0] = 1; tick();
    chk(psr_flat[1:0] == 2'd3, "R10 wake priority", psr_flat[1:0], 3);
    nb_wake = 0; nb_sleep = 0; nb_drain = 0;
    nb_present[1] = 0; nb_sleep[1] = 1; tick();
    chk(psr_flat[3:2] == 2'd0, "R10 absent ignored", psr_flat[3:2], 0);
    nb_present[1] = 1; nb_sleep = 0;

    // R11: acknowledge withheld while busy
    tx_busy[0] = 1; settle();
    chk(!done_out[0] && hold_tx[0], "R11 busy withholds done", {done_out[0], hold_tx[0]}, 2'b01);
    edge_();
    tx_busy = 0; settle();
    chk(done_out[0] && hold_tx[0], "R11 done when idle", {done_out[0], hold_tx[0]}, 2'b11);
    edge_();

    // random phase
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      core_asleep = ($urandom % 8) != 0;
      core_traffic = ($urandom % 16) == 0;
      inbuf_empty = $urandom % 2;
      outlatch_empty = $urandom % 2;
      nb_present = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      nb_drain = 0; nb_sleep = 0; nb_wake = 0; nb_active = 0;
      for (int i = 0; i < NB; i++) if (($urandom % 8) == 0) begin
        case ($urandom % 5)
          0: nb_drain[i] = 1;
          1: nb_sleep[i] = 1;
          2: nb_wake[i] = 1;
          3: nb_active[i] = 1;
          default: begin nb_drain[i] = 1; nb_active[i] = 1; end
        endcase
      end
      nb_done = (($urandom % 3) == 0) ? 4'hF : 4'($urandom);
      nb_deliver = (($urandom % 32) == 0) ? 4'($urandom) : 4'h0;
      tx_busy = 4'($urandom);
      if (($urandom % 64) == 0) nb_id = 16'($urandom);
      tick();
    end
    finish_run();
  end
endmodule